// File: doc/BRIEF.md
# CSR Read-Modify-Write Unit

This unit carries out the six control-and-status-register access operations of an integer core: replace, set-bits and clear-bits, each in a register-operand form and an immediate form. It holds a small parameterised bank of CSRs, each selected by a 12-bit CSR number. In the cycle that `valid_i` is high it returns the CSR's current content for the destination register. It also raises strobes that tell neighbouring logic whether a read side effect or a write side effect takes place. The new value is stored at the next rising clock edge.

Each operation turns into an operand pair (source, mask), and the stored value becomes `(old & ~mask) | (src & mask)`. A zero register index suppresses part of an access. A replace with destination 0 neither reads the CSR nor signals a read. A set or clear whose rs1 field is 0 neither writes nor signals a write. A set or clear that names a nonzero register holding zero still performs a write of the unchanged value.

An access to an address that is not in the bank is flagged illegal, and so is any write aimed at the read-only region. Either case suppresses every effect.

The default bank is as follows:
- 0x340, read-write, resets to 0.
- 0x341, read-write, resets to 0.
- 0x305, read-write, resets to 0x100.
- 0xC01, read-only, holds 0x5EED0001.

Top module: `csr_rmw_unit`

## Requirements
- R1: `op_i` encoding: 3'b001 replace, 3'b010 set, 3'b011 clear, and 3'b101/3'b110/3'b111 the same three in immediate form. A replace stores the operand over all 64 bits. When `mode32_i` is high it stores only bits [31:0], and bits [63:32] keep their old value.
- R2: A set stores `old | operand`. A clear stores `old & ~operand`.
- R3: The immediate forms use `rs1_idx_i` zero-extended to 64 bits as the operand, and `rs1_val_i` is ignored.
- R4: `rd_data_o` carries the CSR content before the update in the same cycle as `valid_i`. The updated value is read back from the following cycle on.
- R5: A replace with `rd_idx_i == 0` keeps `rd_side_o` and `rd_we_o` low, and it still writes the CSR and raises `wr_side_o`.
- R6: A set or clear with `rs1_idx_i == 0` keeps `wr_side_o` low and leaves the CSR unchanged, and it still raises `rd_side_o`. `rd_we_o` is high exactly when `rd_side_o` is high and `rd_idx_i != 0`.
- R7: A set or clear naming a nonzero rs1 index whose value is zero raises `wr_side_o`, and the CSR keeps its value.
- R8: An address outside the bank raises `illegal_o`, keeps `rd_side_o`, `wr_side_o` and `rd_we_o` low, and changes no CSR.
- R9: An address with bits [11:10] == 2'b11 is read-only. Any access that would write it is illegal with no effects. A set or clear with rs1 field 0 reads it normally.
- R10: `op_i` values 3'b000 and 3'b100 are illegal with no effects.
- R11: After reset, each CSR holds its reset value as listed above.
- R12: While `valid_i` is low, all strobes, `rd_we_o` and `illegal_o` are low, and no CSR changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation code (see R1) |
| rd_idx_i | input | 5 | Destination register index |
| rs1_idx_i | input | 5 | Source register index, or immediate operand |
| rs1_val_i | input | 64 | Value of the source register |
| csr_addr_i | input | 12 | CSR number |
| mode32_i | input | 1 | 32-bit mode: replace touches the low half only |
| rd_data_o | output | 64 | CSR content before the update |
| rd_we_o | output | 1 | Write `rd_data_o` to the destination register |
| illegal_o | output | 1 | Illegal-instruction flag |
| rd_side_o | output | 1 | A CSR read took place |
| wr_side_o | output | 1 | A CSR write takes place at the next edge |

## Verification
The assertions assume two things about the inputs. Reset is held for at least two cycles. Inputs are stable around the rising edge, because outputs are combinational from them. The bench drives every input at the falling edge and samples two nanoseconds later. A behavioural model of the bank, indexed by address, predicts every strobe and value and is compared on every operation. Random traffic mixes implemented, unimplemented and read-only addresses, zero and nonzero indices, zero register values and both modes, so that every suppression path is exercised.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;
  localparam int IDX_W  = 5;
  localparam int ADDR_W = 12;

  // op[2] selects the immediate operand, op[1:0] selects the update kind
  typedef enum logic [1:0] {
    K_NONE  = 2'b00,
    K_WRITE = 2'b01,
    K_SET   = 2'b10,
    K_CLEAR = 2'b11
  } csr_kind_e;
endpackage

// File: rtl/csr_op_decode.sv
module csr_op_decode
  import csr_rmw_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [2:0]       op,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [IDX_W-1:0] rs1_idx,
  input  logic [XLEN-1:0]  rs1_val,
  input  logic             mode32,
  output logic             op_ok,
  output logic             want_read,
  output logic             want_write,
  output logic [XLEN-1:0]  src,
  output logic [XLEN-1:0]  mask
);
  localparam logic [XLEN-1:0] LOW_MASK = {XLEN{1'b1}} >> (XLEN - 32);

  logic [XLEN-1:0] operand;
  csr_kind_e       kind;

  assign kind    = csr_kind_e'(op[1:0]);
  assign operand = op[2] ? {{(XLEN-IDX_W){1'b0}}, rs1_idx} : rs1_val;

  always_comb begin
    op_ok      = 1'b1;
    want_read  = 1'b1;
    want_write = 1'b1;
    src        = '0;
    mask       = '0;
    unique case (kind)
      K_WRITE: begin
        want_read = (rd_idx != '0);
        src       = operand;
        mask      = mode32 ? LOW_MASK : {XLEN{1'b1}};
      end
      K_SET: begin
        want_write = (rs1_idx != '0);
        src        = {XLEN{1'b1}};
        mask       = operand;
      end
      K_CLEAR: begin
        want_write = (rs1_idx != '0);
        src        = '0;
        mask       = operand;
      end
      default: begin
        op_ok      = 1'b0;
        want_read  = 1'b0;
        want_write = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/csr_store.sv
module csr_store
  import csr_rmw_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int NUM_CSR = 4,
  parameter logic [NUM_CSR*ADDR_W-1:0] CSR_ADDRS = '0,
  parameter logic [NUM_CSR*XLEN-1:0]   CSR_INIT  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [XLEN-1:0]   wdata,
  output logic              hit,
  output logic [XLEN-1:0]   rdata
);
  logic [NUM_CSR-1:0] match;
  logic [XLEN-1:0]    q [NUM_CSR];

  for (genvar i = 0; i < NUM_CSR; i++) begin : g_entry
    localparam logic [ADDR_W-1:0] A = CSR_ADDRS[i*ADDR_W +: ADDR_W];
    assign match[i] = (addr == A);

    always_ff @(posedge clk) begin
      if (rst)                   q[i] <= CSR_INIT[i*XLEN +: XLEN];
      else if (wr_en && match[i]) q[i] <= wdata;
    end

    // R4: a granted write is visible on the next cycle
    assert_entry_update_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && match[i]) |=> (q[i] == $past(wdata)));

    if (A[ADDR_W-1 -: 2] == 2'b11) begin : g_ro
      // R9: the top never lets a read-only entry change
      assert_ro_stable_R9: assert property (@(posedge clk) disable iff (rst)
        $stable(q[i]));
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CSR; i++)
      if (match[i]) rdata = rdata | q[i];
  end

  assign hit = |match;

  // R8: addresses are unique, at most one entry matches
  assert_one_match_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int NUM_CSR = 4,
  parameter logic [NUM_CSR*ADDR_W-1:0] CSR_ADDRS =
    {12'hC01, 12'h305, 12'h341, 12'h340},
  parameter logic [NUM_CSR*XLEN-1:0] CSR_INIT =
    {64'h0000_0000_5EED_0001, 64'h100, 64'h0, 64'h0}
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        valid_i,
  input  logic [2:0]  op_i,
  input  logic [4:0]  rd_idx_i,
  input  logic [4:0]  rs1_idx_i,
  input  logic [63:0] rs1_val_i,
  input  logic [11:0] csr_addr_i,
  input  logic        mode32_i,
  output logic [63:0] rd_data_o,
  output logic        rd_we_o,
  output logic        illegal_o,
  output logic        rd_side_o,
  output logic        wr_side_o
);
  logic            op_ok, want_read, want_write, hit, ro_region, go;
  logic [XLEN-1:0] src, mask, old_val, new_val;

  csr_op_decode #(.XLEN(XLEN)) u_dec (
    .op(op_i), .rd_idx(rd_idx_i), .rs1_idx(rs1_idx_i), .rs1_val(rs1_val_i),
    .mode32(mode32_i), .op_ok(op_ok), .want_read(want_read),
    .want_write(want_write), .src(src), .mask(mask)
  );

  csr_store #(.XLEN(XLEN), .NUM_CSR(NUM_CSR), .CSR_ADDRS(CSR_ADDRS),
              .CSR_INIT(CSR_INIT)) u_store (
    .clk(clk), .rst(rst), .addr(csr_addr_i), .wr_en(wr_side_o),
    .wdata(new_val), .hit(hit), .rdata(old_val)
  );

  assign ro_region = (csr_addr_i[11:10] == 2'b11);
  assign new_val   = (old_val & ~mask) | (src & mask);
  assign illegal_o = valid_i && (!op_ok || !hit || (want_write && ro_region));
  assign go        = valid_i && !illegal_o;
  assign rd_side_o = go && want_read;
  assign wr_side_o = go && want_write;
  assign rd_we_o   = rd_side_o && (rd_idx_i != 5'd0);
  assign rd_data_o = old_val;

  // R8 / R10: an illegal access has no effect at all
  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !(rd_side_o || wr_side_o || rd_we_o));
  // R5: replace to destination 0 performs no read
  assert_wr_rd0_noread_R5: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i[1:0] == 2'b01 && rd_idx_i == 5'd0) |-> !rd_side_o);
  // R6: set/clear with rs1 field 0 performs no write
  assert_setclr_nowrite_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i[1] && rs1_idx_i == 5'd0) |-> !wr_side_o);
  // R12: idle cycle is quiet
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !valid_i |-> !(rd_side_o || wr_side_o || rd_we_o || illegal_o));
  // R9: no write strobe ever reaches the read-only region
  assert_ro_nowrite_R9: assert property (@(posedge clk) disable iff (rst)
    wr_side_o |-> (csr_addr_i[11:10] != 2'b11));
endmodule

// File: tb/csr_rmw_unit_bench.sv
`timescale 1ns/1ps
module csr_rmw_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [2:0]  op_i;
  logic [4:0]  rd_idx_i, rs1_idx_i;
  logic [63:0] rs1_val_i;
  logic [11:0] csr_addr_i;
  logic        mode32_i;
  logic [63:0] rd_data_o;
  logic        rd_we_o, illegal_o, rd_side_o, wr_side_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  csr_rmw_unit u_csr_rmw_unit (.*);

  // reference model
  logic [11:0] maddr [4] = '{12'h340, 12'h341, 12'h305, 12'hC01};
  logic [63:0] mval  [4];

  function automatic int find(input logic [11:0] a);
    for (int i = 0; i < 4; i++) if (maddr[i] == a) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    mval[0] = 64'h0; mval[1] = 64'h0; mval[2] = 64'h100;
    mval[3] = 64'h0000_0000_5EED_0001;
  endtask

  task automatic issue(input string tag, input logic [2:0] op,
                       input logic [4:0] rd, input logic [4:0] r1,
                       input logic [63:0] r1v, input logic [11:0] a,
                       input logic m32);
    int k; logic [63:0] opnd, old, nxt;
    logic rdo, wro, ill, e_rs, e_ws, e_we;
    @(negedge clk);
    valid_i = 1'b1; op_i = op; rd_idx_i = rd; rs1_idx_i = r1;
    rs1_val_i = r1v; csr_addr_i = a; mode32_i = m32;
    #2;
    k    = find(a);
    opnd = op[2] ? {59'd0, r1} : r1v;
    if (op[1:0] == 2'b01) begin rdo = (rd != 0); wro = 1'b1; end
    else begin rdo = 1'b1; wro = (r1 != 0); end
    ill  = (op[1:0] == 2'b00) || (k < 0) || (wro && a[11:10] == 2'b11);
    e_rs = !ill && rdo;
    e_ws = !ill && wro;
    e_we = e_rs && (rd != 0);
    old  = (k >= 0) ? mval[k] : 64'h0;
    case (op[1:0])
      2'b01:   nxt = m32 ? {old[63:32], opnd[31:0]} : opnd;
      2'b10:   nxt = old | opnd;
      default: nxt = old & ~opnd;
    endcase
    chk(tag, "illegal", {63'd0, illegal_o}, {63'd0, ill});
    chk(tag, "rd_side", {63'd0, rd_side_o}, {63'd0, e_rs});
    chk(tag, "wr_side", {63'd0, wr_side_o}, {63'd0, e_ws});
    chk(tag, "rd_we",   {63'd0, rd_we_o},   {63'd0, e_we});
    if (e_we) chk(tag, "rd_data", rd_data_o, old);
    @(posedge clk); #1;
    if (e_ws) mval[k] = nxt;
    valid_i = 1'b0;
  endtask

  // read a CSR back through a set with rs1 field 0
  task automatic peek(input string tag, input logic [11:0] a,
                      input logic [63:0] exp);
    issue(tag, 3'b010, 5'd1, 5'd0, 64'hFFFF, a, 1'b0);
    chk(tag, "model", mval[find(a)], exp);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    valid_i = 1'b0; op_i = 3'b001; rd_idx_i = 5'd3; rs1_idx_i = 5'd3;
    rs1_val_i = 64'hDEAD; csr_addr_i = 12'h340;
    #2;
    chk(tag, "idle strobes", {60'd0, rd_side_o, wr_side_o, rd_we_o, illegal_o}, 64'd0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    valid_i = 0; op_i = 0; rd_idx_i = 0; rs1_idx_i = 0; rs1_val_i = 0;
    csr_addr_i = 0; mode32_i = 0; rst = 1'b1;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R11 reset values
    peek("R11", 12'h340, 64'h0);
    peek("R11", 12'h305, 64'h100);
    peek("R11", 12'hC01, 64'h5EED0001);
    // R1 replace, full width and 32-bit mode; R4 old value returned
    issue("R1", 3'b001, 5'd2, 5'd7, 64'hAAAA_BBBB_CCCC_DDDD, 12'h340, 1'b0);
    issue("R4", 3'b001, 5'd2, 5'd7, 64'h1111_2222_3333_4444, 12'h340, 1'b1);
    peek("R1", 12'h340, 64'hAAAA_BBBB_3333_4444);
    // R2 set and clear
    issue("R2", 3'b010, 5'd4, 5'd9, 64'h00F0, 12'h341, 1'b0);
    issue("R2", 3'b011, 5'd4, 5'd9, 64'h0030, 12'h341, 1'b0);
    peek("R2", 12'h341, 64'h00C0);
    // R3 immediate forms ignore rs1_val
    issue("R3", 3'b101, 5'd1, 5'd21, 64'hFFFF_FFFF, 12'h305, 1'b0);
    issue("R3", 3'b110, 5'd1, 5'd8, 64'hFFFF_FFFF, 12'h305, 1'b0);
    issue("R3", 3'b111, 5'd1, 5'd1, 64'hFFFF_FFFF, 12'h305, 1'b0);
    peek("R3", 12'h305, 64'd28);
    // R5 replace to x0
    issue("R5", 3'b001, 5'd0, 5'd3, 64'h55, 12'h341, 1'b0);
    issue("R5", 3'b101, 5'd0, 5'd3, 64'h0, 12'h341, 1'b0);
    peek("R5", 12'h341, 64'h3);
    // R6 set/clear with rs1 field 0
    issue("R6", 3'b011, 5'd6, 5'd0, 64'hFFFF, 12'h341, 1'b0);
    issue("R6", 3'b110, 5'd0, 5'd0, 64'hFFFF, 12'h341, 1'b0);
    peek("R6", 12'h341, 64'h3);
    // R7 nonzero register holding zero
    issue("R7", 3'b010, 5'd6, 5'd12, 64'h0, 12'h341, 1'b0);
    issue("R7", 3'b011, 5'd6, 5'd12, 64'h0, 12'h341, 1'b0);
    peek("R7", 12'h341, 64'h3);
    // R8 unimplemented
    issue("R8", 3'b001, 5'd5, 5'd5, 64'h77, 12'h342, 1'b0);
    issue("R8", 3'b010, 5'd5, 5'd0, 64'h77, 12'hC00, 1'b0);
    // R9 read-only region
    issue("R9", 3'b001, 5'd5, 5'd5, 64'h77, 12'hC01, 1'b0);
    issue("R9", 3'b110, 5'd5, 5'd1, 64'h0, 12'hC01, 1'b0);
    issue("R9", 3'b111, 5'd5, 5'd0, 64'h0, 12'hC01, 1'b0);
    peek("R9", 12'hC01, 64'h5EED0001);
    // R10 reserved op codes
    issue("R10", 3'b000, 5'd5, 5'd5, 64'h77, 12'h340, 1'b0);
    issue("R10", 3'b100, 5'd5, 5'd5, 64'h77, 12'h340, 1'b0);
    // R12 idle
    idle("R12");
    idle("R12");
    peek("R12", 12'h340, mval[0]);

    // random traffic
    for (int n = 0; n < 2000; n++) begin
      logic [11:0] a;
      logic [63:0] v;
      int sel;
      sel = $urandom_range(0, 5);
      a = (sel < 4) ? maddr[sel] : ((sel == 4) ? 12'h342 : 12'hC02);
      v = ($urandom_range(0, 3) == 0) ? 64'h0 : {$urandom, $urandom};
      if ($urandom_range(0, 7) == 0) idle("R12");
      issue("RAND", 3'($urandom), ($urandom_range(0, 2) == 0) ? 5'd0 : 5'($urandom),
            ($urandom_range(0, 2) == 0) ? 5'd0 : 5'($urandom), v, a,
            1'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule